// File: doc/BRIEF.md
# SPI Master Port

A full-duplex serial master that drives its own serial clock, shifts a byte out on the data-out line and, over the same bit times, shifts a byte in from the data-in line. A host writes a byte through a strobe and the transfer begins on that same clock edge. There is no separate start command. When the eighth bit is done, the received byte lands in a read buffer. A buffer-full flag rises and a single-cycle interrupt pulse is issued.

The host picks the idle level of the serial clock and the phase, which decides whether the first data bit is on the line before the first clock edge. It also picks whether input is captured in the middle or at the end of each bit, and where the bit rate comes from. The bit rate comes from one of three fixed system-clock divisors or from an external timer tick, with two ticks per bit. A receive-only control turns the data-out driver off while transfers still run and fill the buffer. Two sticky error flags record writes made during a transfer and bytes that arrive while the buffer is still full. A dedicated strobe clears them.

Top module: `spi_master_port`

## Requirements
- R1: A write strobe while idle starts a transfer in the same clock edge. `busy_o` is high in the next cycle, and `sdo_o` already shows bit 7 of the written byte.
- R2: Transmit and receive run at once, most significant bit first. The byte written appears on `sdo_o` bit 7 first, and the byte received is assembled with the first captured bit in bit 7.
- R3: `rate_sel_i` encodes the bit rate: 0 = clock/DIV_A, 1 = clock/DIV_B, 2 = clock/DIV_C, 3 = external tick/2. With 0 to 2 a byte keeps `busy_o` high for exactly 8·DIV clock cycles. With 3 it ends after exactly 16 ticks sampled while busy.
- R4: While no transfer runs, `sck_o` equals `cpol_i`.
- R5: With `cke_i`=1, `sck_o` stays idle for the first half of each bit and toggles at mid-bit. With `cke_i`=0, `sck_o` leaves idle at the start of each bit. In both cases `sdo_o` changes only at bit boundaries.
- R6: With `smp_i`=0 each input bit is captured at mid-bit. With `smp_i`=1 it is captured at the end of the bit.
- R7: At the end of a byte, `rdata_o` takes the received byte, `buf_full_o` is set and `irq_o` is high for exactly one cycle. `busy_o` falls in the same cycle.
- R8: A read strobe `rd_i` clears `buf_full_o`.
- R9: With `rx_only_i`=1, `sdo_oe_o` is low. A write still runs a full transfer, which loads the received byte into the buffer as usual.
- R10: A write during a transfer has no effect on the byte being sent or received, and it sets the sticky `wcol_o`. `clr_err_i` clears `wcol_o`.
- R11: A byte that completes while `buf_full_o` is set and no read occurs is dropped. `rdata_o` keeps the earlier byte, and the sticky `ovf_o` is set until `clr_err_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_i | input | 1 | write strobe for the transmit byte |
| wdata_i | input | DATA_W | transmit byte |
| rd_i | input | 1 | read strobe, acknowledges the buffer |
| clr_err_i | input | 1 | clears the sticky error flags |
| cpol_i | input | 1 | serial clock idle level |
| cke_i | input | 1 | 1: data valid before the first clock edge |
| smp_i | input | 1 | 0: capture at mid-bit, 1: capture at end of bit |
| rate_sel_i | input | 2 | bit-rate source select |
| rx_only_i | input | 1 | disables the data-out driver |
| tmr_tick_i | input | 1 | external timer tick, one cycle wide |
| sdi_i | input | 1 | serial data in |
| sck_o | output | 1 | serial clock |
| sdo_o | output | 1 | serial data out |
| sdo_oe_o | output | 1 | data-out driver enable |
| rdata_o | output | DATA_W | received byte buffer |
| busy_o | output | 1 | transfer in progress |
| buf_full_o | output | 1 | buffer holds an unread byte |
| irq_o | output | 1 | completion pulse |
| wcol_o | output | 1 | sticky write collision |
| ovf_o | output | 1 | sticky receive overflow |

## Verification
The bench uses the default parameters: an 8-bit byte and divisors of 4, 16 and 64. At divisor 4 a byte lasts only 32 cycles, so exact cycle-by-cycle checks of the clock level, the data-out bit and the fall of busy are cheap. A single run at divisor 64 exercises the widest prescaler count. A bench-driven timer tick every third cycle exercises the external source. In that case the length of a transfer is counted in ticks, not cycles. A directed run drives the data-in line with different values in the two halves of every bit, so that a mid-bit capture and an end-of-bit capture give different bytes.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  typedef enum logic [1:0] {
    RATE_DIV_A = 2'd0,
    RATE_DIV_B = 2'd1,
    RATE_DIV_C = 2'd2,
    RATE_TMR   = 2'd3
  } rate_e;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_master_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  rate_e sel_i,
  input  logic  tmr_tick_i,
  output logic  half_tick_o
);
  localparam int CW = $clog2(DIV_C) + 1;

  logic [CW-1:0] cnt_q, lim;

  always_comb begin
    unique case (sel_i)
      RATE_DIV_A: lim = CW'(DIV_A / 2 - 1);
      RATE_DIV_B: lim = CW'(DIV_B / 2 - 1);
      default:    lim = CW'(DIV_C / 2 - 1);
    endcase
  end

  // one tick per half bit; the timer source gives half bits directly
  assign half_tick_o = run_i && ((sel_i == RATE_TMR) ? tmr_tick_i : (cnt_q == lim));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i || half_tick_o)  cnt_q <= '0;
    else if (sel_i != RATE_TMR)      cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && sel_i != RATE_TMR |-> cnt_q <= lim); // R3
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cpol_i,
  input  logic              cke_i,
  input  logic              smp_i,
  input  logic              sdi_i,
  input  logic              half_tick_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int HALVES = 2 * DATA_W;
  localparam int HW     = $clog2(HALVES);
  localparam logic [HW-1:0] LAST = HW'(HALVES - 1);

  logic              busy_q;
  logic [HW-1:0]     hcnt_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
  logic              second_half;

  assign second_half = hcnt_q[0];
  assign done_o      = busy_q && half_tick_i && (hcnt_q == LAST);
  assign busy_o      = busy_q;
  assign sdo_o       = tx_sh_q[DATA_W-1];
  // phase 1: active in second half; phase 0: active in first half
  assign sck_o       = cpol_i ^ (busy_q && (cke_i ? second_half : !second_half));
  // end-of-bit capture of the last bit merges the live input
  assign rx_byte_o   = smp_i ? {rx_sh_q[DATA_W-2:0], sdi_i} : rx_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      hcnt_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      hcnt_q  <= '0;
      tx_sh_q <= data_i;
      rx_sh_q <= '0;
    end else if (busy_q && half_tick_i) begin
      hcnt_q <= hcnt_q + 1'b1;
      if (!second_half) begin
        if (!smp_i) rx_sh_q <= {rx_sh_q[DATA_W-2:0], sdi_i};
      end else begin
        if (smp_i) rx_sh_q <= {rx_sh_q[DATA_W-2:0], sdi_i};
        tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
        if (hcnt_q == LAST) busy_q <= 1'b0;
      end
    end
  end

  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q && hcnt_q == '0); // R1
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !half_tick_i && !start_i |=> $stable(tx_sh_q)); // R5
  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q); // R7
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              clr_err_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              start_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              buf_full_o,
  output logic              irq_o,
  output logic              wcol_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] buf_q;
  logic              full_q, irq_q, wcol_q, ovf_q;
  logic              accept;

  assign start_o    = wr_i && !busy_i;
  assign accept     = done_i && (!full_q || rd_i);
  assign rdata_o    = buf_q;
  assign buf_full_o = full_q;
  assign irq_o      = irq_q;
  assign wcol_o     = wcol_q;
  assign ovf_o      = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      wcol_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      irq_q <= done_i;
      if (accept) begin
        buf_q  <= rx_byte_i;
        full_q <= 1'b1;
      end else if (rd_i) begin
        full_q <= 1'b0;
      end
      if (done_i && !accept) ovf_q <= 1'b1;
      else if (clr_err_i)    ovf_q <= 1'b0;
      if (wr_i && busy_i)    wcol_q <= 1'b1;
      else if (clr_err_i)    wcol_q <= 1'b0;
    end
  end

  AST_IRQ_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q); // R7
  AST_FULL_WITH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> full_q); // R7
  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !done_i |=> !full_q); // R8
  AST_WCOL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && busy_i |=> wcol_q); // R10
  AST_OVF_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && full_q && !rd_i |=> $stable(buf_q) && ovf_q); // R11
endmodule

// File: rtl/spi_master_port.sv
module spi_master_port
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16,
  parameter int DIV_C  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              clr_err_i,
  input  logic              cpol_i,
  input  logic              cke_i,
  input  logic              smp_i,
  input  logic [1:0]        rate_sel_i,
  input  logic              rx_only_i,
  input  logic              tmr_tick_i,
  input  logic              sdi_i,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              buf_full_o,
  output logic              irq_o,
  output logic              wcol_o,
  output logic              ovf_o
);
  logic              start, busy, half_tick, done;
  logic [DATA_W-1:0] rx_byte;

  assign busy_o   = busy;
  assign sdo_oe_o = !rx_only_i;

  spi_rate_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (busy),
    .sel_i      (rate_e'(rate_sel_i)),
    .tmr_tick_i (tmr_tick_i),
    .half_tick_o(half_tick)
  );

  spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .data_i     (wdata_i),
    .cpol_i     (cpol_i),
    .cke_i      (cke_i),
    .smp_i      (smp_i),
    .sdi_i      (sdi_i),
    .half_tick_i(half_tick),
    .busy_o     (busy),
    .sck_o      (sck_o),
    .sdo_o      (sdo_o),
    .done_o     (done),
    .rx_byte_o  (rx_byte)
  );

  spi_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .clr_err_i (clr_err_i),
    .busy_i    (busy),
    .done_i    (done),
    .rx_byte_i (rx_byte),
    .start_o   (start),
    .rdata_o   (rdata_o),
    .buf_full_o(buf_full_o),
    .irq_o     (irq_o),
    .wcol_o    (wcol_o),
    .ovf_o     (ovf_o)
  );
endmodule

// File: tb/spi_master_port_test.sv
`timescale 1ns/1ps
module spi_master_port_test;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       wr_i = 0, rd_i = 0, clr_err_i = 0;
  logic [7:0] wdata_i = '0;
  logic       cpol_i = 0, cke_i = 1, smp_i = 0, rx_only_i = 0, tmr_tick_i = 0, sdi_i = 0;
  logic [1:0] rate_sel_i = 2'd0;
  logic       sck_o, sdo_o, sdo_oe_o, busy_o, buf_full_o, irq_o, wcol_o, ovf_o;
  logic [7:0] rdata_o;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  spi_master_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i),
    .clr_err_i(clr_err_i), .cpol_i(cpol_i), .cke_i(cke_i), .smp_i(smp_i),
    .rate_sel_i(rate_sel_i), .rx_only_i(rx_only_i), .tmr_tick_i(tmr_tick_i),
    .sdi_i(sdi_i), .sck_o(sck_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .rdata_o(rdata_o), .busy_o(busy_o), .buf_full_o(buf_full_o), .irq_o(irq_o),
    .wcol_o(wcol_o), .ovf_o(ovf_o)
  );

  // timer tick every third cycle, driven between edges
  int tick_cnt = 0;
  always @(posedge clk) begin
    #1.25;
    tick_cnt++;
    tmr_tick_i = (tick_cnt % 3 == 0);
  end

  // slave model: advances on bit-boundary clock edges, captures on the others
  logic       slave_en = 0;
  logic [7:0] sl_byte = '0, cap = '0;
  logic       sck_prev = 0;
  int         bcnt = 0, sidx = 0;
  always @(posedge clk) begin
    #1.25;
    if (slave_en && sck_o !== sck_prev) begin
      if (cke_i ? (sck_o == cpol_i) : (sck_o != cpol_i)) begin
        bcnt++;
        sidx = cke_i ? bcnt : bcnt - 1;
        if (sidx >= 0 && sidx < 8) sdi_i = sl_byte[7 - sidx];
      end else begin
        cap = {cap[6:0], sdo_o};
      end
    end
    sck_prev = sck_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] b);
    @(negedge clk); wr_i = 1; wdata_i = b;
    @(negedge clk); wr_i = 0;
  endtask

  task automatic do_read();
    @(negedge clk); rd_i = 1;
    @(negedge clk); rd_i = 0;
  endtask

  task automatic arm(input logic [7:0] sl);
    @(negedge clk);
    sl_byte = sl; cap = '0; bcnt = 0; sdi_i = sl[7]; slave_en = 1;
  endtask

  // run a transfer to completion from the sample after the start edge
  task automatic finish_xfer(output int dur, output int ticks);
    dur = 0; ticks = 0;
    while (busy_o && dur < 5000) begin
      dur++;
      if (tmr_tick_i) ticks++;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic       cpol, cke, smp;
    logic [1:0] rate;
    logic [7:0] tx, sl;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 2'd0, 8'hA5, 8'h3C},
    '{1'b0, 1'b0, 1'b1, 2'd0, 8'h81, 8'h7E},
    '{1'b1, 1'b1, 1'b1, 2'd1, 8'hC3, 8'h5A},
    '{1'b1, 1'b0, 1'b0, 2'd3, 8'h0F, 8'hF0},
    '{1'b0, 1'b1, 1'b1, 2'd2, 8'h96, 8'h01},
    '{1'b1, 1'b1, 1'b0, 2'd0, 8'hFF, 8'h80}
  };

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int dur, ticks, exp_dur;
    repeat (3) @(negedge clk);
    // reset state
    chk(busy_o == 0 && buf_full_o == 0 && irq_o == 0, "R7 reset", {busy_o, buf_full_o, irq_o}, 0);
    chk(wcol_o == 0 && ovf_o == 0 && rdata_o == 0, "R10 reset", {wcol_o, ovf_o, rdata_o}, 0);
    chk(sck_o == 0, "R4 reset idle", sck_o, 0);
    rst_ni = 1;
    @(negedge clk);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cpol_i = VECS[i].cpol; cke_i = VECS[i].cke; smp_i = VECS[i].smp; rate_sel_i = VECS[i].rate;
      @(negedge clk);
      chk(sck_o == VECS[i].cpol, "R4 idle level", sck_o, VECS[i].cpol);
      arm(VECS[i].sl);
      do_write(VECS[i].tx);
      chk(busy_o == 1 && sdo_o == VECS[i].tx[7], "R1 start", {busy_o, sdo_o}, {1'b1, VECS[i].tx[7]});
      finish_xfer(dur, ticks);
      if (VECS[i].rate == 2'd3) begin
        chk(ticks == 16, "R3 timer ticks", ticks, 16);
      end else begin
        exp_dur = (VECS[i].rate == 2'd0) ? 32 : (VECS[i].rate == 2'd1) ? 128 : 512;
        chk(dur == exp_dur, "R3 duration", dur, exp_dur);
      end
      chk(irq_o == 1 && buf_full_o == 1, "R7 completion", {irq_o, buf_full_o}, 3);
      chk(rdata_o == VECS[i].sl, "R2 R6 rx byte", rdata_o, VECS[i].sl);
      chk(cap == VECS[i].tx, "R2 tx msb first", cap, VECS[i].tx);
      @(negedge clk);
      chk(irq_o == 0, "R7 irq single cycle", irq_o, 0);
      chk(sck_o == VECS[i].cpol, "R4 idle after", sck_o, VECS[i].cpol);
      slave_en = 0;
      do_read();
      chk(buf_full_o == 0, "R8 read clears", buf_full_o, 0);
    end

    // R5 clock placement, phase 1 then phase 0, divisor 4
    for (int ph = 1; ph >= 0; ph--) begin
      @(negedge clk); cpol_i = 0; cke_i = ph[0]; smp_i = 0; rate_sel_i = 2'd0;
      do_write(8'h6D);
      chk(sck_o == !ph[0], "R5 sck at bit start", sck_o, !ph[0]);
      chk(sdo_o == 1'b0, "R5 first bit", sdo_o, 0);
      @(negedge clk);
      chk(sck_o == !ph[0], "R5 sck first half", sck_o, !ph[0]);
      @(negedge clk);
      chk(sck_o == ph[0], "R5 sck second half", sck_o, ph[0]);
      @(negedge clk); @(negedge clk);
      chk(sdo_o == 1'b1, "R5 sdo at bit boundary", sdo_o, 1);
      finish_xfer(dur, ticks);
      do_read();
    end

    // R6 capture point: different values in the two halves of each bit
    for (int s = 0; s < 2; s++) begin
      @(negedge clk); cpol_i = 0; cke_i = 1; smp_i = s[0]; rate_sel_i = 2'd0;
      sdi_i = 1'b1;
      do_write(8'h00);
      for (int n = 0; n < 32; n++) begin
        sdi_i = (n % 4 < 2) ? 8'hC9 >> (7 - n / 4) : 8'h36 >> (7 - n / 4);
        @(negedge clk);
      end
      chk(rdata_o == (s ? 8'h36 : 8'hC9), "R6 sample point", rdata_o, s ? 8'h36 : 8'hC9);
      do_read();
    end

    // R9 receive only
    @(negedge clk); rx_only_i = 1; cke_i = 1; smp_i = 0; rate_sel_i = 2'd0;
    @(negedge clk);
    chk(sdo_oe_o == 0, "R9 driver off", sdo_oe_o, 0);
    arm(8'hB4);
    do_write(8'hFF);
    finish_xfer(dur, ticks);
    chk(buf_full_o == 1 && rdata_o == 8'hB4, "R9 rx still loads", rdata_o, 8'hB4);
    slave_en = 0;
    do_read();
    rx_only_i = 0;
    @(negedge clk);
    chk(sdo_oe_o == 1, "R9 driver on", sdo_oe_o, 1);

    // R10 write collision
    arm(8'h33);
    do_write(8'h5A);
    repeat (4) @(negedge clk);
    @(negedge clk); wr_i = 1; wdata_i = 8'hFF;
    @(negedge clk); wr_i = 0;
    chk(wcol_o == 1, "R10 wcol set", wcol_o, 1);
    finish_xfer(dur, ticks);
    chk(dur == 32 - 6, "R10 transfer not restarted", dur, 26);
    chk(cap == 8'h5A && rdata_o == 8'h33, "R10 data unaffected", {cap, rdata_o}, 16'h5A33);
    slave_en = 0;
    // R11 overflow: buffer not read
    arm(8'hE7);
    do_write(8'h11);
    finish_xfer(dur, ticks);
    chk(ovf_o == 1, "R11 ovf set", ovf_o, 1);
    chk(rdata_o == 8'h33, "R11 old byte kept", rdata_o, 8'h33);
    slave_en = 0;
    do_read();
    chk(buf_full_o == 0, "R8 read clears after ovf", buf_full_o, 0);
    chk(wcol_o == 1 && ovf_o == 1, "R10 R11 sticky", {wcol_o, ovf_o}, 3);
    @(negedge clk); clr_err_i = 1;
    @(negedge clk); clr_err_i = 0;
    chk(wcol_o == 0 && ovf_o == 0, "R10 R11 clear", {wcol_o, ovf_o}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule